// File: doc/BRIEF.md
# Dual-Channel Bus Control Register Slave

This block is a two-wire serial bus slave that holds the control settings for two independent power channels, called A and B. It samples the bus clock and data lines with the system clock, finds START and STOP conditions, and decodes the 7-bit address that follows a START. Each channel has two possible addresses. A strap input for that channel picks which one it uses. The slave pulls the data line low through an open-drain enable whenever it has to send a 0.

A write moves one data byte into the control register of the addressed channel. The full byte appears on that channel's control output. A read returns a status byte. Three bits of it echo the control register and two bits carry the live over-temperature and over-load flags of the channel. The status byte is sent again for as long as the master keeps acknowledging. An undervoltage input silences the slave and clears both registers.

Top module: `dual_ctl_bus_slave`

## Requirements
- R1: Channel A answers at 7-bit address 0001000 when strap[0] is 0 and at 0001001 when strap[0] is 1. It does not answer at the other address of the pair.
- R2: Channel B answers at 7-bit address 0001010 when strap[1] is 0 and at 0001011 when strap[1] is 1.
- R3: The address byte carries the address in bits 7..1, MSB first, and the read flag in bit 0 (1 means read). The slave acknowledges a matching address and the data byte of a write. The data byte then appears unchanged on that channel's control output, and the other channel keeps its value. An address that matches no channel gets no acknowledge and changes nothing.
- R4: The read byte, MSB first, is {0, 0, 0, ctrl[4], ctrl[3], ctrl[2], over_temp, over_load} of the addressed channel. The fault flags are sampled when each byte starts.
- R5: When the master acknowledges a read byte, the slave sends the status byte again. When the master does not acknowledge, the slave releases the data line and stays silent until the next STOP.
- R6: A write stores only one data byte. Any later bytes in the same transfer get no acknowledge and are not stored.
- R7: While uv_i is 1, the slave gives no acknowledge and both control registers read 0. They stay 0 after uv_i falls until they are written again.
- R8: After reset both control outputs are 0 and sda_oe is 0.
- R9: A START that follows a previous START with no STOP in between abandons the transfer. Nothing is acknowledged until a STOP and then a new START.
- R10: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When 1, the slave pulls the data line low |
| uv_i | input | 1 | Undervoltage: silences the slave and clears the registers |
| strap | input | 2 | Address strap, bit 0 for channel A, bit 1 for channel B |
| over_temp | input | 2 | Live over-temperature flag per channel |
| over_load | input | 2 | Live over-load flag per channel |
| ctrl_a | output | 8 | Control register of channel A |
| ctrl_b | output | 8 | Control register of channel B |

## Verification
A shift or bit-count error in the receive path shows up at the next acknowledge clock. The expected low on the data line is missing, or it lands on the wrong channel, and the control output then holds a value that differs from the byte written. A wrong transmit pointer or a wrong reload after a master acknowledge corrupts the very next read byte. A state machine left in the wrong state after a repeated START, a NACK or undervoltage shows at the ports as an unexpected acknowledge within one byte time. The same fault can also show as a changed control output or as an edge on the data-line enable while SCL is high.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned NCH = 2;
  localparam int unsigned CH_W = $clog2(NCH);
  localparam logic [6:0] BASE_ADDR = 7'b0001000;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_WAIT
  } bus_st_e;

  // The channel index fills bit 1 of the address and the strap fills bit 0.
  function automatic logic [6:0] chan_addr(input int unsigned ch, input logic strap_bit);
    return BASE_ADDR | 7'(ch << 1) | {6'b0, strap_bit};
  endfunction

  // The read-back byte: three zero bits, then three echoed control bits, then the two live flags.
  function automatic logic [7:0] status_byte(input logic [7:0] ctrl, input logic ot, input logic ol);
    return {3'b000, ctrl[4:2], ot, ol};
  endfunction
endpackage

// File: rtl/i2cs_sync_edge.sv
module i2cs_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic prev;

  // The bus idles high, so the chain resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/i2cs_chan_reg.sv
module i2cs_chan_reg
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       ot,
  input  logic       ol,
  output logic [7:0] ctrl,
  output logic [7:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl <= '0;
    else if (uv) ctrl <= '0;
    else if (wr) ctrl <= wdata;
  end

  assign status = status_byte(ctrl, ot, ol);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !uv) |=> $stable(ctrl));
  assert_uv_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> (ctrl == 8'h00));
endmodule

// File: rtl/i2cs_bus_fsm.sv
module i2cs_bus_fsm
  import i2cs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    uv,
  input  logic                    scl,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic                    sda,
  input  logic                    start_ev,
  input  logic                    stop_ev,
  input  logic [NCH-1:0][6:0]     addr_tab,
  input  logic [NCH-1:0][7:0]     status_tab,
  output logic                    sda_oe,
  output logic                    wr_pulse,
  output logic [CH_W-1:0]         wr_sel,
  output logic [7:0]              wr_data
);
  bus_st_e         st;
  logic            bus_free;
  logic [3:0]      cnt;
  logic [7:0]      sh;
  logic            rd;
  logic            mack;
  logic            hit;
  logic [CH_W-1:0] hit_idx;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int c = 0; c < NCH; c++) begin
      if (sh[7:1] == addr_tab[c]) begin
        hit = 1'b1;
        hit_idx = CH_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bus_free <= 1'b1; sda_oe <= 1'b0; cnt <= '0;
      sh <= '0; rd <= 1'b0; mack <= 1'b0; wr_pulse <= 1'b0; wr_sel <= '0;
    end else begin
      wr_pulse <= 1'b0;
      if (uv || stop_ev) begin
        st <= S_IDLE; bus_free <= 1'b1; sda_oe <= 1'b0;
      end else if (start_ev) begin
        sda_oe <= 1'b0; cnt <= '0; bus_free <= 1'b0;
        st <= bus_free ? S_ADDR : S_WAIT;
      end else begin
        unique case (st)
          S_ADDR, S_WDAT: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_WDAT) begin
                wr_pulse <= 1'b1; sda_oe <= 1'b1; st <= S_WACK;
              end else if (hit) begin
                sda_oe <= 1'b1; wr_sel <= hit_idx; rd <= sh[0]; st <= S_AACK;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rd) begin
              sh <= status_tab[wr_sel]; sda_oe <= ~status_tab[wr_sel][7]; st <= S_RDAT;
            end else begin
              sda_oe <= 1'b0; st <= S_WDAT;
            end
          end
          S_WACK: if (scl_fall) begin
            sda_oe <= 1'b0; st <= S_WAIT;
          end
          S_RDAT: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= S_RACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 4'd1;
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda;
            else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                sh <= status_tab[wr_sel]; sda_oe <= ~status_tab[wr_sel][7]; st <= S_RDAT;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_data = sh;

  assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);
  assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  assert_uv_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> (!sda_oe && !wr_pulse));
  assert_no_drive_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT || st == S_IDLE) |-> !sda_oe);
endmodule

// File: rtl/dual_ctl_bus_slave.sv
module dual_ctl_bus_slave
  import i2cs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       uv_i,
  input  logic [1:0] strap,
  input  logic [1:0] over_temp,
  input  logic [1:0] over_load,
  output logic [7:0] ctrl_a,
  output logic [7:0] ctrl_b
);
  logic scl_q, scl_rise, scl_fall;
  logic sda_q, sda_rise, sda_fall;
  logic start_ev, stop_ev;
  logic wr_pulse;
  logic [CH_W-1:0] wr_sel;
  logic [7:0] wr_data;
  logic [NCH-1:0][6:0] addr_tab;
  logic [NCH-1:0][7:0] status_tab;
  logic [NCH-1:0][7:0] ctrl;

  i2cs_sync_edge #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .q(scl_q), .rise(scl_rise), .fall(scl_fall));
  i2cs_sync_edge #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .q(sda_q), .rise(sda_rise), .fall(sda_fall));

  assign start_ev = scl_q & sda_fall;
  assign stop_ev  = scl_q & sda_rise;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign addr_tab[c] = chan_addr(c, strap[c]);
    i2cs_chan_reg u_reg (
      .clk(clk), .rst_n(rst_n), .uv(uv_i),
      .wr(wr_pulse && (wr_sel == CH_W'(c))), .wdata(wr_data),
      .ot(over_temp[c]), .ol(over_load[c]),
      .ctrl(ctrl[c]), .status(status_tab[c]));
  end

  i2cs_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .uv(uv_i), .scl(scl_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda(sda_q),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .addr_tab(addr_tab), .status_tab(status_tab),
    .sda_oe(sda_oe), .wr_pulse(wr_pulse), .wr_sel(wr_sel), .wr_data(wr_data));

  assign ctrl_a = ctrl[0];
  assign ctrl_b = ctrl[1];

  assert_write_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !uv_i);
endmodule

// File: tb/sim_dual_ctl_bus_slave.sv
module sim_dual_ctl_bus_slave;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic uv = 1'b0;
  logic [1:0] strap = 2'b00, ot = 2'b00, ol = 2'b00;
  logic sda_oe;
  logic [7:0] ctrl_a, ctrl_b;
  wire sda_line = sda_m & ~sda_oe;

  int ncmp = 0, nerr = 0, viol = 0;
  bit done = 0;
  logic [7:0] exp_ctrl [2];

  always #5 clk = ~clk;

  dual_ctl_bus_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .uv_i(uv), .strap(strap), .over_temp(ot), .over_load(ol),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b));

  // R10 monitor: the enable may only move while the clock line is low
  always @(sda_oe) if (rst_n && scl_m) viol++;

  function automatic logic [6:0] exp_addr(input int ch, input logic s);
    return {5'b00010, ch[0], s};
  endfunction
  function automatic logic [7:0] exp_stat(input int ch);
    logic [7:0] r = exp_ctrl[ch];
    return {3'b000, r[4], r[3], r[2], ot[ch], ol[ch]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    ncmp++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic bstart;
    sda_m = 1; scl_m = 1; wq; sda_m = 0; wq; scl_m = 0; wq;
  endtask
  task automatic bstop;
    sda_m = 0; wq; scl_m = 1; wq; sda_m = 1; wq; wq;
  endtask
  task automatic rstart;
    sda_m = 1; wq; scl_m = 1; wq; sda_m = 0; wq; scl_m = 0; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq; scl_m = 1; wq; scl_m = 0; wq;
    end
    sda_m = 1; wq; scl_m = 1; wq; ack = ~sda_line; scl_m = 0; wq;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq; scl_m = 1; wq; b[i] = sda_line; scl_m = 0;
    end
    wq; sda_m = mack ? 1'b0 : 1'b1; wq; scl_m = 1; wq; scl_m = 0; wq; sda_m = 1;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, output bit aa, output bit ad);
    bstart; send_byte({a, 1'b0}, aa); send_byte(d, ad); bstop;
  endtask

  task automatic check_regs(input string req);
    chk({req, " ctrl_a"}, ctrl_a, exp_ctrl[0]);
    chk({req, " ctrl_b"}, ctrl_b, exp_ctrl[1]);
  endtask

  task automatic do_read(input int ch, input int nb, input string req);
    bit ak; logic [7:0] b;
    bstart; send_byte({exp_addr(ch, strap[ch]), 1'b1}, ak);
    chk({req, " read addr ack"}, ak, 1);
    for (int k = 0; k < nb; k++) begin
      recv_byte(k < nb - 1, b);
      chk({req, " read byte"}, b, exp_stat(ch));
    end
    bstop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; ncmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end

  initial begin
    bit aa, ad, ak;
    logic [7:0] b;
    exp_ctrl[0] = 0; exp_ctrl[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    wq;
    // R8 reset state
    chk("R8 ctrl_a", ctrl_a, 0); chk("R8 ctrl_b", ctrl_b, 0); chk("R8 sda_oe", sda_oe, 0);

    // R1 / R3 channel A with strap low
    do_write(7'b0001000, 8'hA5, aa, ad);
    chk("R1 addr ack", aa, 1); chk("R3 data ack", ad, 1);
    exp_ctrl[0] = 8'hA5; check_regs("R3");
    // R2 channel B with strap low
    do_write(7'b0001010, 8'h3C, aa, ad);
    chk("R2 addr ack", aa, 1); exp_ctrl[1] = 8'h3C; check_regs("R2");
    // R1 / R2 strap high: the old addresses are silent
    strap = 2'b11; wq;
    do_write(7'b0001000, 8'h11, aa, ad); chk("R1 old addr nack", aa, 0); check_regs("R1");
    do_write(7'b0001010, 8'h22, aa, ad); chk("R2 old addr nack", aa, 0); check_regs("R2");
    do_write(7'b0001001, 8'h5A, aa, ad); chk("R1 strap addr ack", aa, 1);
    do_write(7'b0001011, 8'hC3, aa, ad); chk("R2 strap addr ack", aa, 1);
    exp_ctrl[0] = 8'h5A; exp_ctrl[1] = 8'hC3; check_regs("R1 R2");
    // R3 no channel matches
    do_write(7'h50, 8'hFF, aa, ad); chk("R3 foreign nack", aa, 0); check_regs("R3");

    // R4 / R5 repeated read with faults
    ot = 2'b01; ol = 2'b10; wq;
    do_read(0, 3, "R4 R5 chan A");
    do_read(1, 2, "R4 chan B");
    // R5 nack then silence
    bstart; send_byte({exp_addr(0, 1'b1), 1'b1}, ak);
    recv_byte(1'b0, b); chk("R4 nack byte", b, exp_stat(0));
    recv_byte(1'b1, b); chk("R5 silent after nack", b, 8'hFF);
    bstop;

    // R6 second data byte ignored
    bstart; send_byte({exp_addr(1, 1'b1), 1'b0}, aa); send_byte(8'h96, ad);
    send_byte(8'h00, ak); bstop;
    chk("R6 first ack", ad, 1); chk("R6 second nack", ak, 0);
    exp_ctrl[1] = 8'h96; check_regs("R6");

    // R9 repeated start abandons the transfer
    bstart; send_byte({exp_addr(0, 1'b1), 1'b0}, aa);
    rstart; send_byte({exp_addr(1, 1'b1), 1'b0}, ak); send_byte(8'h44, ad); bstop;
    chk("R9 first ack", aa, 1); chk("R9 addr nack", ak, 0); chk("R9 data nack", ad, 0);
    check_regs("R9");
    do_write(exp_addr(0, 1'b1), 8'h0F, aa, ad); chk("R9 recovers", aa, 1);
    exp_ctrl[0] = 8'h0F; check_regs("R9");

    // R7 undervoltage
    uv = 1; wq;
    exp_ctrl[0] = 0; exp_ctrl[1] = 0; check_regs("R7 during");
    do_write(exp_addr(0, 1'b1), 8'h77, aa, ad); chk("R7 nack", aa, 0);
    uv = 0; wq; check_regs("R7 after");

    // random mix
    for (int n = 0; n < 120; n++) begin
      int ch = $urandom_range(0, 1);
      logic [7:0] d = 8'($urandom);
      strap = 2'($urandom); ot = 2'($urandom); ol = 2'($urandom);
      wq;
      if ($urandom_range(0, 2) != 0) begin
        do_write(exp_addr(ch, strap[ch]), d, aa, ad);
        chk("R3 random ack", aa & ad, 1);
        exp_ctrl[ch] = d; check_regs("R3 random");
      end else begin
        do_read(ch, $urandom_range(1, 3), "R4 random");
      end
    end

    chk("R10 oe edges with SCL high", viol, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule